// File: doc/BRIEF.md
# Gamma Curve Segment Builder

This block turns a per-component gamma lookup table into the compact form a piecewise-linear gamma stage consumes. A pulse on `start` makes it walk the red, green and blue components in turn. For each of the segments it reads two samples of the table, one at each end of the segment, through a synchronous read port. It keeps the top bits of each sample. From the two values it builds a breakpoint, an offset and a non-negative fixed-point gradient. Each segment then leaves the block as two packed words, each with a write strobe and a word index.

The gradient is the rise across the segment, scaled by 16, divided by the segment span (samples per segment minus one). A multi-cycle restoring divider does the division. A falling segment is flattened to a zero gradient. A second mode, selected by `ident` together with `start`, emits the identity curve without touching the table. This mode supplies power-up contents to the gamma stage.

Top module: `gamma_pwl_builder`

## Requirements
- R1: After reset, `busy`, `ent_we`, `done` and `tbl_rd_en` are all low, and they stay low until a start pulse.
- R2: Words leave in component order red (0), green (1), blue (2), with points 0 to 15 ascending within each component. Each point gives two words: the offset word first and the gradient word second. `ent_idx` = component*32 + point*2 + word, so bit 0 is 0 for the offset word and 1 for the gradient word.
- R3: For point i of component c, the block reads table address i*16 (segment start) and then i*16+15 (segment end), with `tbl_rd_comp` = c. Each sample arrives on `tbl_rd_data` one cycle after its read request.
- R4: An offset word holds the breakpoint i<<8 in bits [31:20] and C in bits [15:0], with bits [19:16] zero. In table mode, C = s<<4, where s = sample[15:4] of the start sample.
- R5: A gradient word holds G in bits [11:0], with bits [31:12] zero. In table mode, G is the low 12 bits of ((e - s)<<4)/15, where e = sample[15:4] of the end sample.
- R6: If the end value is below the start value, the end is taken equal to the start, so G = 0.
- R7: A start pulse with `ident` high emits, for every component and point i, C = i<<12 and G = 256 (unity slope), with the same breakpoints, and makes no table reads.
- R8: `busy` rises in the cycle after an accepted start pulse. `done` is high for exactly one cycle, in the cycle after the last gradient word (index 95). `busy` is low in the cycle after `done`.
- R9: A start pulse, with either value of `ident`, while `busy` is high is ignored: the running conversion neither restarts nor changes mode, and no extra words follow it.
- R10: A quotient above 4095 is truncated to its low 12 bits (a full-scale rise of 4095 gives 4368, emitted as 272).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; accepted only while idle |
| ident | input | 1 | Sampled with start: 1 selects the identity curve |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse after the final word |
| tbl_rd_en | output | 1 | Table read request |
| tbl_rd_comp | output | 2 | Component of the read (0 red, 1 green, 2 blue) |
| tbl_rd_addr | output | 8 | Table address of the read |
| tbl_rd_data | input | 16 | Read sample, valid one cycle after the request |
| ent_we | output | 1 | Entry word write strobe |
| ent_idx | output | 7 | Entry word index |
| ent_data | output | 32 | Packed entry word |

## Verification
The hardest case to reach is a start pulse that arrives in the middle of a conversion, during a divider run. If it were accepted, it would restart the sequence or switch the mode without any visible gap. To reach it, the stimulus fires such pulses, with `ident` both low and high, at fixed offsets after a table-mode start, so that they land inside divider waits. The scoreboard holds exactly one conversion's worth of expected words and reads, and then watches a quiet window after `done`. The table contents are shaped so that every component contains rising, falling and full-scale segments. This covers the flattening and truncation paths next to ordinary gradients.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD_S  = 3'd1,
      ST_RD_E  = 3'd2,
      ST_CAP_E = 3'd3,
      ST_DIV   = 3'd4,
      ST_EMIT0 = 3'd5,
      ST_EMIT1 = 3'd6,
      ST_DONE  = 3'd7
   } pwl_state_e;

   function automatic int unsigned bits_for(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/pwl_seg_seq.sv
module pwl_seg_seq #(
   parameter int unsigned TBL_DEPTH = 256,
   parameter int unsigned NPTS      = 16,
   parameter int unsigned NCOMP     = 3,
   localparam int unsigned AW   = pwl_pkg::bits_for(TBL_DEPTH),
   localparam int unsigned PW   = pwl_pkg::bits_for(NPTS),
   localparam int unsigned CW   = pwl_pkg::bits_for(NCOMP),
   localparam int unsigned STEP = TBL_DEPTH / NPTS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          advance,
   output logic [CW-1:0] comp,
   output logic [PW-1:0] pt,
   output logic          last,
   output logic [AW-1:0] addr_start,
   output logic [AW-1:0] addr_end
);
   localparam logic [PW-1:0] PT_LAST   = PW'(NPTS - 1);
   localparam logic [CW-1:0] COMP_LAST = CW'(NCOMP - 1);

   logic [CW-1:0] comp_q;
   logic [PW-1:0] pt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         comp_q <= '0;
         pt_q   <= '0;
      end else if (clear) begin
         comp_q <= '0;
         pt_q   <= '0;
      end else if (advance) begin
         if (pt_q == PT_LAST) begin
            pt_q   <= '0;
            comp_q <= (comp_q == COMP_LAST) ? '0 : comp_q + 1'b1;
         end else begin
            pt_q <= pt_q + 1'b1;
         end
      end
   end

   always_comb begin
      comp       = comp_q;
      pt         = pt_q;
      last       = (pt_q == PT_LAST) && (comp_q == COMP_LAST);
      addr_start = AW'(32'(pt_q) * STEP);
      addr_end   = AW'(32'(pt_q) * STEP + (STEP - 1));
   end
endmodule

// File: rtl/pwl_restoring_div.sv
module pwl_restoring_div #(
   parameter int unsigned DVD_W = 16,
   parameter int unsigned DVS_W = 4,
   localparam int unsigned CNT_W = pwl_pkg::bits_for(DVD_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [DVD_W-1:0] dividend,
   input  logic [DVS_W-1:0] divisor,
   output logic             fin,
   output logic [DVD_W-1:0] quotient
);
   logic [DVS_W:0]   rem_q;
   logic [DVD_W-1:0] quo_q;
   logic [DVS_W-1:0] dvs_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             fin_q;

   logic [DVS_W:0] rem_sh;
   logic           fits;

   always_comb begin
      rem_sh = {rem_q[DVS_W-1:0], quo_q[DVD_W-1]};
      fits   = (rem_sh >= {1'b0, dvs_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         dvs_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (go) begin
            rem_q <= '0;
            quo_q <= dividend;
            dvs_q <= divisor;
            cnt_q <= CNT_W'(DVD_W);
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= fits ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
            quo_q <= {quo_q[DVD_W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end
         end
      end
   end

   assign fin      = fin_q;
   assign quotient = quo_q;
endmodule

// File: rtl/pwl_entry_pack.sv
module pwl_entry_pack #(
   parameter int unsigned SAMP_W  = 16,
   parameter int unsigned VAL_W   = 12,
   parameter int unsigned C_FRAC  = 4,
   parameter int unsigned GRAD_W  = 12,
   parameter int unsigned GRAD_FB = 8,
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned X_LSB   = 20,
   parameter int unsigned NPTS    = 16,
   localparam int unsigned PW     = pwl_pkg::bits_for(NPTS),
   localparam int unsigned C_W    = VAL_W + C_FRAC,
   localparam int unsigned X_W    = WORD_W - X_LSB
) (
   input  logic [SAMP_W-1:0] raw_sample,
   output logic [VAL_W-1:0]  sample_val,
   input  logic              ident,
   input  logic [PW-1:0]     pt,
   input  logic [VAL_W-1:0]  start_val,
   input  logic [GRAD_W-1:0] grad_val,
   output logic [WORD_W-1:0] word_off,
   output logic [WORD_W-1:0] word_grad
);
   generate
      if (SAMP_W >= VAL_W) begin : g_trim
         assign sample_val = raw_sample[SAMP_W-1 -: VAL_W];
      end else begin : g_widen
         assign sample_val = {raw_sample, {(VAL_W - SAMP_W){1'b0}}};
      end
   endgenerate

   logic [X_W-1:0]    x_val;
   logic [C_W-1:0]    c_val;
   logic [GRAD_W-1:0] g_val;

   always_comb begin
      x_val = X_W'(pt) << (X_W - PW);
      if (ident) begin
         c_val = C_W'(pt) << (C_W - PW);
         g_val = GRAD_W'(1) << GRAD_FB;
      end else begin
         c_val = {start_val, {C_FRAC{1'b0}}};
         g_val = grad_val;
      end
      word_off                    = '0;
      word_off[WORD_W-1:X_LSB]    = x_val;
      word_off[C_W-1:0]           = c_val;
      word_grad                   = '0;
      word_grad[GRAD_W-1:0]       = g_val;
   end
endmodule

// File: rtl/gamma_pwl_builder.sv
module gamma_pwl_builder #(
   parameter int unsigned TBL_DEPTH = 256,
   parameter int unsigned NPTS      = 16,
   parameter int unsigned NCOMP     = 3,
   parameter int unsigned SAMP_W    = 16,
   parameter int unsigned VAL_W     = 12,
   parameter int unsigned C_FRAC    = 4,
   parameter int unsigned GRAD_W    = 12,
   parameter int unsigned GRAD_FB   = 8,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned X_LSB     = 20,
   localparam int unsigned AW    = pwl_pkg::bits_for(TBL_DEPTH),
   localparam int unsigned PW    = pwl_pkg::bits_for(NPTS),
   localparam int unsigned CW    = pwl_pkg::bits_for(NCOMP),
   localparam int unsigned IDX_W = pwl_pkg::bits_for(NCOMP * NPTS * 2),
   localparam int unsigned STEP  = TBL_DEPTH / NPTS,
   localparam int unsigned DVD_W = VAL_W + C_FRAC,
   localparam int unsigned DVS_W = pwl_pkg::bits_for(STEP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ident,
   output logic              busy,
   output logic              done,
   output logic              tbl_rd_en,
   output logic [CW-1:0]     tbl_rd_comp,
   output logic [AW-1:0]     tbl_rd_addr,
   input  logic [SAMP_W-1:0] tbl_rd_data,
   output logic              ent_we,
   output logic [IDX_W-1:0]  ent_idx,
   output logic [WORD_W-1:0] ent_data
);
   import pwl_pkg::*;

   generate
      if (TBL_DEPTH % NPTS != 0) begin : g_bad_split
         $error("table depth must be a multiple of the point count");
      end
      if (STEP < 2) begin : g_bad_step
         $error("each segment needs at least two samples");
      end
      if (VAL_W + C_FRAC > X_LSB) begin : g_bad_pack
         $error("offset field overlaps the breakpoint field");
      end
      if (GRAD_W > WORD_W || X_LSB >= WORD_W) begin : g_bad_word
         $error("fields do not fit the entry word");
      end
      if (WORD_W - X_LSB < PW) begin : g_bad_x
         $error("breakpoint field too narrow for the point index");
      end
   endgenerate

   pwl_state_e state_q, state_d;
   logic       ident_q;
   logic [VAL_W-1:0]  s_q;
   logic [GRAD_W-1:0] grad_q;

   logic [CW-1:0] comp;
   logic [PW-1:0] pt;
   logic          last;
   logic [AW-1:0] a_start, a_end;
   logic          seq_clear, seq_adv;

   logic [VAL_W-1:0]  samp_val;
   logic [VAL_W-1:0]  e_clamped;
   logic [DVD_W-1:0]  div_dividend;
   logic              div_go, div_fin;
   logic [DVD_W-1:0]  div_quo;
   logic [WORD_W-1:0] w_off, w_grad;

   pwl_seg_seq #(
      .TBL_DEPTH(TBL_DEPTH), .NPTS(NPTS), .NCOMP(NCOMP)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .clear(seq_clear), .advance(seq_adv),
      .comp(comp), .pt(pt), .last(last),
      .addr_start(a_start), .addr_end(a_end)
   );

   pwl_restoring_div #(
      .DVD_W(DVD_W), .DVS_W(DVS_W)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .go(div_go),
      .dividend(div_dividend), .divisor(DVS_W'(STEP - 1)),
      .fin(div_fin), .quotient(div_quo)
   );

   pwl_entry_pack #(
      .SAMP_W(SAMP_W), .VAL_W(VAL_W), .C_FRAC(C_FRAC), .GRAD_W(GRAD_W),
      .GRAD_FB(GRAD_FB), .WORD_W(WORD_W), .X_LSB(X_LSB), .NPTS(NPTS)
   ) u_pack (
      .raw_sample(tbl_rd_data), .sample_val(samp_val),
      .ident(ident_q), .pt(pt), .start_val(s_q), .grad_val(grad_q),
      .word_off(w_off), .word_grad(w_grad)
   );

   always_comb begin
      e_clamped    = (samp_val < s_q) ? s_q : samp_val;
      div_dividend = {e_clamped - s_q, {C_FRAC{1'b0}}};
      div_go       = (state_q == ST_CAP_E);
      seq_clear    = (state_q == ST_IDLE);
      seq_adv      = (state_q == ST_EMIT1) && !last;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start) state_d = ident ? ST_EMIT0 : ST_RD_S;
         ST_RD_S:  state_d = ST_RD_E;
         ST_RD_E:  state_d = ST_CAP_E;
         ST_CAP_E: state_d = ST_DIV;
         ST_DIV:   if (div_fin) state_d = ST_EMIT0;
         ST_EMIT0: state_d = ST_EMIT1;
         ST_EMIT1: begin
            if (last)         state_d = ST_DONE;
            else if (ident_q) state_d = ST_EMIT0;
            else              state_d = ST_RD_S;
         end
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ident_q <= 1'b0;
         s_q     <= '0;
         grad_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start) ident_q <= ident;
         if (state_q == ST_RD_E)          s_q     <= samp_val;
         if (state_q == ST_DIV && div_fin) grad_q <= div_quo[GRAD_W-1:0];
      end
   end

   logic is_emit;

   always_comb begin
      is_emit     = (state_q == ST_EMIT0) || (state_q == ST_EMIT1);
      busy        = (state_q != ST_IDLE);
      done        = (state_q == ST_DONE);
      tbl_rd_en   = (state_q == ST_RD_S) || (state_q == ST_RD_E);
      tbl_rd_comp = comp;
      tbl_rd_addr = (state_q == ST_RD_E) ? a_end : a_start;
      ent_we      = is_emit;
      ent_idx     = IDX_W'(32'(comp) * (2 * NPTS) + 32'(pt) * 2
                           + ((state_q == ST_EMIT1) ? 1 : 0));
      ent_data    = (state_q == ST_EMIT1) ? w_grad : w_off;
   end
endmodule

// File: rtl/pwl_builder_chk.sv
module pwl_builder_chk #(
   parameter int unsigned IDX_W  = 7,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned GRAD_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              tbl_rd_en,
   input logic              ident_q,
   input logic              ent_we,
   input logic [IDX_W-1:0]  ent_idx,
   input logic [WORD_W-1:0] ent_data
);
   always_comb begin
      if (!rst_n) begin
         assert_quiet_in_reset_R1: assert (!busy && !ent_we && !done && !tbl_rd_en);
      end
   end

   assert_write_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ent_we |-> busy);

   assert_word_pairing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_we && !ent_idx[0]) |=> (ent_we && ent_idx[0]
                                    && ent_idx[IDX_W-1:1] == $past(ent_idx[IDX_W-1:1])));

   assert_read_needs_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_rd_en |-> busy);

   assert_grad_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_we && ent_idx[0]) |-> (ent_data[WORD_W-1:GRAD_W] == '0));

   assert_ident_no_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ident_q) |-> !tbl_rd_en);

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

bind gamma_pwl_builder pwl_builder_chk #(
   .IDX_W(IDX_W), .WORD_W(WORD_W), .GRAD_W(GRAD_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .tbl_rd_en(tbl_rd_en), .ident_q(ident_q), .ent_we(ent_we),
   .ent_idx(ent_idx), .ent_data(ent_data)
);

// File: tb/sim_gamma_pwl_builder.sv
module sim_gamma_pwl_builder;
   localparam int NCOMP = 3;
   localparam int DEPTH = 256;
   localparam int NPTS  = 16;
   localparam int STEP  = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        ident = 1'b0;
   logic        busy, done, tbl_rd_en, ent_we;
   logic [1:0]  tbl_rd_comp;
   logic [7:0]  tbl_rd_addr;
   logic [15:0] tbl_rd_data;
   logic [6:0]  ent_idx;
   logic [31:0] ent_data;

   always #10 clk = ~clk;

   gamma_pwl_builder u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .ident(ident),
      .busy(busy), .done(done), .tbl_rd_en(tbl_rd_en),
      .tbl_rd_comp(tbl_rd_comp), .tbl_rd_addr(tbl_rd_addr),
      .tbl_rd_data(tbl_rd_data), .ent_we(ent_we), .ent_idx(ent_idx),
      .ent_data(ent_data)
   );

   logic [15:0] mem [NCOMP*DEPTH];
   always_ff @(posedge clk) begin
      if (tbl_rd_en) tbl_rd_data <= mem[32'(tbl_rd_comp) * DEPTH + 32'(tbl_rd_addr)];
   end

   typedef struct {
      logic [6:0]  idx;
      logic [31:0] data;
      string       tag;
   } exp_word_t;

   typedef struct {
      logic [1:0] comp;
      logic [7:0] addr;
   } exp_rd_t;

   exp_word_t wq[$];
   exp_rd_t   rq[$];
   int checks = 0;
   int fails  = 0;
   int last_idx = -1;
   int done_seen = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver side: compute the expected words from the requirements.
   task automatic push_expected(input bit id);
      for (int c = 0; c < NCOMP; c++) begin
         for (int i = 0; i < NPTS; i++) begin
            int s, e, g;
            exp_word_t w0, w1;
            string gt;
            if (id) begin
               s = i << 8;
               g = 256;
               gt = "R7";
            end else begin
               s = int'(mem[c*DEPTH + i*STEP][15:4]);
               e = int'(mem[c*DEPTH + i*STEP + STEP - 1][15:4]);
               gt = "R5";
               if (e < s) begin e = s; gt = "R6"; end
               g = ((e - s) << 4) / (STEP - 1);
               if (g > 4095) gt = "R10";
               g = g & 12'hFFF;
               rq.push_back('{comp: 2'(c), addr: 8'(i*STEP)});
               rq.push_back('{comp: 2'(c), addr: 8'(i*STEP + STEP - 1)});
            end
            w0.idx = 7'(c*32 + i*2);
            w0.data = (32'(i << 8) << 20) | 32'(s << 4);
            w0.tag = id ? "R7" : "R4";
            w1.idx = 7'(c*32 + i*2 + 1);
            w1.data = 32'(g);
            w1.tag = gt;
            wq.push_back(w0);
            wq.push_back(w1);
         end
      end
   endtask

   // Monitor: compare design output against the queues.
   always @(negedge clk) begin
      if (rst_n && ent_we) begin
         if (wq.size() == 0) begin
            check(1'b0, "R9 unexpected word", {25'd0, ent_idx}, 32'd0);
         end else begin
            exp_word_t w;
            w = wq.pop_front();
            check(ent_idx == w.idx, "R2 index", {25'd0, ent_idx}, {25'd0, w.idx});
            check(ent_data == w.data, w.tag, ent_data, w.data);
         end
         last_idx = int'(ent_idx);
      end
      if (rst_n && tbl_rd_en) begin
         if (rq.size() == 0) begin
            check(1'b0, "R7 unexpected read", {22'd0, tbl_rd_comp, tbl_rd_addr}, 32'd0);
         end else begin
            exp_rd_t r;
            r = rq.pop_front();
            check(tbl_rd_comp == r.comp && tbl_rd_addr == r.addr, "R3 read",
                  {22'd0, tbl_rd_comp, tbl_rd_addr}, {22'd0, r.comp, r.addr});
         end
      end
      if (rst_n && done) done_seen++;
   end

   task automatic pulse_start(input bit id);
      @(negedge clk);
      start = 1'b1;
      ident = id;
      @(negedge clk);
      start = 1'b0;
      ident = 1'b0;
   endtask

   task automatic run(input bit id, input bit disturb);
      int guard;
      done_seen = 0;
      push_expected(id);
      pulse_start(id);
      check(busy == 1'b1, "R8 busy rise", {31'd0, busy}, 32'd1);
      if (disturb) begin
         repeat (7) @(negedge clk);
         start = 1'b1; ident = 1'b1;
         @(negedge clk);
         start = 1'b0; ident = 1'b0;
         repeat (30) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (!done && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      check(done == 1'b1, "R8 done reached", {31'd0, done}, 32'd1);
      check(last_idx == 95, "R8 done after last word", 32'(last_idx), 32'd95);
      @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R8 idle after done", {30'd0, busy, done}, 32'd0);
      repeat (40) @(negedge clk);
      check(done_seen == 1, "R9 single done", 32'(done_seen), 32'd1);
      check(wq.size() == 0 && rq.size() == 0, "R9 queues drained",
            32'(wq.size() + rq.size()), 32'd0);
      wq.delete();
      rq.delete();
   endtask

   task automatic fill(input int pat);
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int c = 0; c < NCOMP; c++) begin
         for (int a = 0; a < DEPTH; a++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (pat)
               0: mem[c*DEPTH + a] = 16'(a * 257);
               1: mem[c*DEPTH + a] = lf;
               default: begin
                  // Alternate rising, falling and full-scale segments.
                  case ((a / STEP + c) % 3)
                     0: mem[c*DEPTH + a] = 16'((a % STEP == 0) ? 0 : 16'hFFFF);
                     1: mem[c*DEPTH + a] = 16'(16'hF000 - (a % STEP) * 16'h0800);
                     default: mem[c*DEPTH + a] = 16'(a * 200 + c * 77);
                  endcase
               end
            endcase
         end
      end
   endtask

   initial begin
      fill(0);
      repeat (3) @(negedge clk);
      check(!busy && !ent_we && !done && !tbl_rd_en, "R1 reset outputs",
            {28'd0, busy, ent_we, done, tbl_rd_en}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!busy && !ent_we && !done && !tbl_rd_en, "R1 idle after reset",
            {28'd0, busy, ent_we, done, tbl_rd_en}, 32'd0);
      run(1'b1, 1'b0);
      run(1'b0, 1'b0);
      fill(1);
      run(1'b0, 1'b1);
      fill(2);
      run(1'b0, 1'b0);
      run(1'b1, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int cyc;
      cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end
endmodule